// File: doc/BRIEF.md
# Page Buffer Write Controller

This block is the synchronous page-write engine of a byte-wide nonvolatile memory model. A host presents byte-load strobes, each carrying an address and one data byte. The low address bits pick a byte column inside a 128-byte page, and the upper bits pick the page. Accepted bytes collect in a page buffer. The load phase stays open for as long as each new strobe comes within an idle window counted in clock cycles. There is no limit on how long the phase lasts or on how many strobes it takes.

Once the idle window passes with no strobe, the block enters a fixed-length internal write cycle and raises `busy`. When that cycle ends it emits a one-cycle commit. The commit carries the page of the most recently loaded byte and all 128 bytes at once. Columns that were not loaded in this phase read as FFh. A behavioural array outside the block takes the commit and stores the page in one step. Strobes that arrive while `busy` is high are dropped.

Top module: `page_write_ctrl`

## Requirements
- R1: During and right after reset, `busy` and `commit_valid` are low.
- R2: A page holds PAGE_BYTES (128) bytes. `load_addr[6:0]` is the column and `load_addr[ADDR_W-1:7]` is the page. Column k appears in `commit_data[8k+7:8k]`.
- R3: A strobe on any of the CLOSE_CYCLES clock edges after the previous accepted strobe is accepted and keeps the load phase open. With such spacing the phase can last any length of time.
- R4: If none of those CLOSE_CYCLES edges carries a strobe, `busy` is high in the cycle after the last of them.
- R5: Loading a column a second time in the same phase replaces the byte held for it.
- R6: `commit_page` equals the page field of the last accepted byte of the phase.
- R7: Every column not loaded during the current phase is committed as FFh.
- R8: `busy` stays high for exactly WRITE_CYCLES cycles. `commit_valid` is high for the single cycle in which `busy` has just fallen, and it carries the whole page at once.
- R9: Strobes while `busy` is high are ignored. They change neither the committed page nor any committed byte, and they do not lengthen the write cycle.
- R10: The first accepted strobe after a commit starts a new phase. Bytes loaded in earlier phases are not carried into it and commit as FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_stb | input | 1 | Byte-load strobe, one byte per cycle it is high |
| load_addr | input | ADDR_W | Byte address: page field above the column field |
| load_data | input | 8 | Byte to load |
| busy | output | 1 | Internal write cycle in progress |
| commit_valid | output | 1 | One-cycle pulse: commit the page now |
| commit_page | output | ADDR_W-7 | Page being committed |
| commit_data | output | PAGE_BYTES*8 | Full page image, unloaded columns as FFh |

## Verification
The bench spaces strobes exactly CLOSE_CYCLES-1 idle cycles apart, which places each one on the last edge that still counts. A timer that is off by one would close the phase early and commit a partial page, or it would never raise `busy`. The bench reloads a column and then switches page on the final byte. A design that latched the first page or kept the first byte would commit the wrong page or a stale value. The bench also fires strobes during the write cycle, which a leaky design would merge into the image or use to stretch `busy`. A final one-byte phase follows a full phase, and a buffer that was never cleared would leak old bytes in place of FFh.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // column index inside a page
  function automatic int unsigned col_index(input logic [31:0] addr, input int unsigned col_w);
    return addr & ((32'd1 << col_w) - 32'd1);
  endfunction

  // page number above the column field
  function automatic int unsigned page_index(input logic [31:0] addr, input int unsigned col_w);
    return addr >> col_w;
  endfunction

  // committed view of one buffer byte
  function automatic logic [7:0] shown_byte(input logic loaded, input logic [7:0] held);
    return loaded ? held : ERASED_BYTE;
  endfunction

endpackage

// File: rtl/pwc_interval_timer.sv
module pwc_interval_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(LIMIT) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired = enable && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (enable && !expired) cnt_q <= cnt_q + 1'b1;
  end

  // R3 / R8: the count never runs past its window
  p_timer_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_restart_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);

endmodule

// File: rtl/pwc_page_buffer.sv
module pwc_page_buffer #(
  parameter int unsigned PAGE_BYTES = 128,
  localparam int unsigned COL_W = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    fresh,
  input  logic [COL_W-1:0]        wr_col,
  input  logic [7:0]              wr_byte,
  output logic [PAGE_BYTES-1:0]   loaded,
  output logic [PAGE_BYTES*8-1:0] image
);
  genvar gi;
  generate
    for (gi = 0; gi < PAGE_BYTES; gi++) begin : g_byte
      logic       hit;
      logic [7:0] held_q;
      logic       loaded_q;

      assign hit = wr_en && (wr_col == COL_W'(gi));

      always_ff @(posedge clk) begin
        if (!rst_n)     held_q <= '0;
        else if (hit)   held_q <= wr_byte;
      end

      always_ff @(posedge clk) begin
        if (!rst_n)                loaded_q <= 1'b0;
        else if (hit)              loaded_q <= 1'b1;
        else if (wr_en && fresh)   loaded_q <= 1'b0;
      end

      assign loaded[gi]          = loaded_q;
      assign image[gi*8 +: 8]    = pwc_pkg::shown_byte(loaded_q, held_q);
    end
  endgenerate

  // R10: a fresh phase leaves exactly the one new column marked
  p_fresh_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fresh) |=> $countones(loaded) == 1);

  // R5: a write marks its column loaded
  p_write_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> loaded != '0);

endmodule

// File: rtl/pwc_phase_ctrl.sv
module pwc_phase_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_stb,
  input  logic            idle_expired,
  input  logic            write_expired,
  output pwc_pkg::phase_e phase,
  output logic            accept,
  output logic            new_phase,
  output logic            enter_write,
  output logic            commit_q
);
  import pwc_pkg::*;

  phase_e phase_q, phase_d;
  logic   finish;

  assign accept      = load_stb && (phase_q != PH_WRITE);
  assign new_phase   = accept && (phase_q == PH_IDLE);
  assign enter_write = (phase_q == PH_LOAD) && !load_stb && idle_expired;
  assign finish      = (phase_q == PH_WRITE) && write_expired;
  assign phase       = phase_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (accept)      phase_d = PH_LOAD;
      PH_LOAD:  if (enter_write) phase_d = PH_WRITE;
      PH_WRITE: if (finish)      phase_d = PH_IDLE;
      default:                   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      commit_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      commit_q <= finish;
    end
  end

  // R9: the write cycle never hands back to loading directly
  p_no_load_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase_q) == PH_WRITE |-> phase_q != PH_LOAD);

  // R4: the write cycle is only entered from an open load phase
  p_write_from_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WRITE && $past(phase_q) != PH_WRITE) |-> $past(phase_q) == PH_LOAD);

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned PAGE_BYTES   = 128,
  parameter int unsigned CLOSE_CYCLES = 64,
  parameter int unsigned WRITE_CYCLES = 256,
  localparam int unsigned COL_W  = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W = ADDR_W - COL_W,
  localparam int unsigned IMG_W  = PAGE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [7:0]        load_data,
  output logic              busy,
  output logic              commit_valid,
  output logic [PAGE_W-1:0] commit_page,
  output logic [IMG_W-1:0]  commit_data
);
  import pwc_pkg::*;

  phase_e              phase;
  logic                accept, new_phase, enter_write;
  logic                idle_expired, write_expired;
  logic [COL_W-1:0]    addr_col;
  logic [PAGE_W-1:0]   addr_page;
  logic [PAGE_W-1:0]   page_q;
  logic [PAGE_BYTES-1:0] fill_mask;

  assign addr_col  = COL_W'(col_index(32'(load_addr), COL_W));
  assign addr_page = PAGE_W'(page_index(32'(load_addr), COL_W));

  pwc_phase_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_stb      (load_stb),
    .idle_expired  (idle_expired),
    .write_expired (write_expired),
    .phase         (phase),
    .accept        (accept),
    .new_phase     (new_phase),
    .enter_write   (enter_write),
    .commit_q      (commit_valid)
  );

  pwc_interval_timer #(.LIMIT(CLOSE_CYCLES)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .enable  (phase == PH_LOAD),
    .expired (idle_expired)
  );

  pwc_interval_timer #(.LIMIT(WRITE_CYCLES)) u_write (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (enter_write),
    .enable  (phase == PH_WRITE),
    .expired (write_expired)
  );

  pwc_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .fresh   (new_phase),
    .wr_col  (addr_col),
    .wr_byte (load_data),
    .loaded  (fill_mask),
    .image   (commit_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      page_q <= '0;
    else if (accept) page_q <= addr_page;
  end

  assign busy        = (phase == PH_WRITE);
  assign commit_page = page_q;

  // R4: closing the window raises busy on the next cycle
  p_busy_after_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_write |=> busy && !commit_valid);

  // R8: commit sits exactly on the busy falling cycle, one cycle wide
  p_commit_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> !busy && $past(busy));
  p_fall_gives_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> commit_valid);
  p_commit_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);

  // R9: nothing in the buffer or page moves while writing
  p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fill_mask));
  p_page_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(commit_page));

  // R10: only a strobe from idle opens a phase
  p_fresh_only_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    new_phase |-> !busy);

endmodule

// File: tb/tb_page_write_ctrl.sv
`timescale 1ns/1ps
module tb_page_write_ctrl;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned PB     = 128;
  localparam int unsigned CLOSE  = 12;
  localparam int unsigned WRITE  = 30;
  localparam int unsigned PAGE_W = ADDR_W - 7;
  localparam int unsigned IMG_W  = PB * 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              load_stb;
  logic [ADDR_W-1:0] load_addr;
  logic [7:0]        load_data;
  logic              busy, commit_valid;
  logic [PAGE_W-1:0] commit_page;
  logic [IMG_W-1:0]  commit_data;

  always #2 clk = ~clk;

  page_write_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .CLOSE_CYCLES(CLOSE),
                    .WRITE_CYCLES(WRITE)) dut (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_addr(load_addr),
    .load_data(load_data), .busy(busy), .commit_valid(commit_valid),
    .commit_page(commit_page), .commit_data(commit_data));

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [IMG_W-1:0]  img;
  } commit_t;

  commit_t           exp_q[$];
  int                n_cmp = 0, n_bad = 0, busy_run = 0, seen = 0;
  logic [IMG_W-1:0]  m_img;
  logic [PAGE_W-1:0] m_page;
  bit                m_fresh = 1'b1;
  bit                done = 1'b0;
  string             img_req = "R7";

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  // accepted byte: model updated
  task automatic load(input int page, input int col, input logic [7:0] v);
    load_addr = ADDR_W'((page << 7) | col);
    load_data = v;
    load_stb  = 1'b1;
    if (m_fresh) begin m_img = '1; m_fresh = 1'b0; end
    m_img[col*8 +: 8] = v;
    m_page = PAGE_W'(page);
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  // strobe during busy: model untouched
  task automatic poke(input int page, input int col, input logic [7:0] v);
    load_addr = ADDR_W'((page << 7) | col);
    load_data = v;
    load_stb  = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic close_phase();
    gap(CLOSE - 1);
    check(busy == 1'b0, "R4", 64'(busy), 64'd0);
    gap(1);
    check(busy == 1'b1, "R4", 64'(busy), 64'd1);
    exp_q.push_back('{page: m_page, img: m_img});
    m_fresh = 1'b1;
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    gap(2);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (commit_valid) begin
        commit_t e;
        seen++;
        check(busy == 1'b0 && busy_run == WRITE, "R8", 64'(busy_run), 64'(WRITE));
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", 64'd1, 64'd0);
        end else begin
          e = exp_q.pop_front();
          check(commit_page == e.page, "R6", 64'(commit_page), 64'(e.page));
          n_cmp++;
          if (commit_data !== e.img) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", img_req, commit_data, e.img);
          end
        end
        busy_run = 0;
      end
      if (busy) busy_run++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_stb = 1'b0; load_addr = '0; load_data = '0;
    gap(3);
    check(busy == 1'b0, "R1", 64'(busy), 64'd0);
    check(commit_valid == 1'b0, "R1", 64'(commit_valid), 64'd0);
    rst_n = 1'b1;
    gap(2);
    check(busy == 1'b0 && commit_valid == 1'b0, "R1", 64'({busy, commit_valid}), 64'd0);

    // single byte: rest reads erased (R7)
    img_req = "R7";
    load(3, 5, 8'h5A);
    close_phase();
    drain();

    // full page, every column (R2)
    img_req = "R2";
    for (int i = 0; i < PB; i++) load(10, i, 8'(i * 3 + 1));
    close_phase();
    drain();

    // widest legal spacing, overwrite, page switch on last byte (R3 R5 R6)
    img_req = "R5";
    load(1, 0, 8'hAA);
    for (int k = 0; k < 4; k++) begin
      gap(CLOSE - 1);
      check(busy == 1'b0, "R3", 64'(busy), 64'd0);
      load(1, 2 + k, 8'(8'h20 + k));
    end
    gap(CLOSE - 1);
    load(1, 0, 8'h11);
    gap(CLOSE - 1);
    check(busy == 1'b0, "R3", 64'(busy), 64'd0);
    load(7, 9, 8'h99);
    close_phase();
    // strobes during the write cycle (R9)
    poke(2, 0, 8'h00);
    poke(7, 9, 8'h00);
    gap(3);
    poke(7, 100, 8'h00);
    check(busy == 1'b1, "R9", 64'(busy), 64'd1);
    drain();

    // new phase on same page starts clean (R10)
    img_req = "R10";
    load(7, 50, 8'h50);
    close_phase();
    drain();

    // top page field bits and top column (R2)
    img_req = "R2";
    load(9'h155, 0, 8'h3C);
    load(9'h1FF, 127, 8'hC3);
    close_phase();
    drain();

    check(seen == 5 && exp_q.size() == 0, "R8", 64'(seen), 64'd5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule